// File: doc/BRIEF.md
# Programmable Duty-Cycle Serial Clock Generator

This block derives the serial clock of a two-wire bus master from the peripheral clock. Software writes two 16-bit period registers. One sets how many peripheral clock cycles the clock line stays low. The other sets how many cycles it stays high. The bit rate is the peripheral clock frequency divided by the sum of the two counts. Because the counts are independent, the duty cycle can be asymmetric, as fast-mode timing needs. Any written count below 4 is raised to 4.

The clock line is open-drain. The block drives a pull-low enable: when it is 1, the line is pulled low; when it is 0, the line is released high. Generation starts in the low phase as soon as the block is enabled. A new count is taken only when a phase begins, so a phase that has already started keeps its length. A hold input stretches the low phase. A one-cycle tick marks each falling and each rising transition, for a bit-level sequencer to use.

Top module: `scl_rate_gen`

## Requirements
- R1: After reset, `scl_pull_low` is 0, both ticks are 0, and both period counts are 4.
- R2: A low phase lasts exactly the low count in peripheral clock cycles, with `scl_pull_low` = 1 for each of those cycles.
- R3: A high phase lasts exactly the high count in cycles, with `scl_pull_low` = 0. The full period is the high count plus the low count.
- R4: A write of a value below 4 stores 4. A write to the high count uses `wr_sel` = 0, and a write to the low count uses `wr_sel` = 1.
- R5: When `enable` rises, the next cycle is the first cycle of a low phase, and `tick_fall` is 1 in that cycle.
- R6: A phase uses the count held in its register when the phase starts. A write during a phase changes only later phases.
- R7: While `hold` is 1 during a low phase, the line stays pulled low and the phase does not advance. The phase resumes where it stopped when `hold` drops.
- R8: When `enable` is 0 at a clock edge, the line is released in the next cycle, and the phase state is cleared. A later enable starts a complete low phase.
- R9: `tick_fall` is 1 only in the first cycle of a low phase. `tick_rise` is 1 only in the first cycle of a high phase. The two ticks are never 1 together.
- R10: `hold` has no effect during a high phase.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Peripheral clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Period register write strobe |
| wr_sel | input | 1 | Register select: 0 = high count, 1 = low count |
| wr_data | input | 16 | Count to write |
| enable | input | 1 | Run the generator |
| hold | input | 1 | Stretch the low phase |
| scl_pull_low | output | 1 | 1 pulls the clock line low; 0 releases it |
| tick_rise | output | 1 | One-cycle pulse in the first high cycle |
| tick_fall | output | 1 | One-cycle pulse in the first low cycle |

## Verification
A wrong count, length or phase bit shows on `scl_pull_low` at the next phase boundary, within one programmed period. It appears as a phase that is too long or too short, or as a tick at the wrong cycle. A missed clamp shows as a low or high phase shorter than 4 cycles. A count that is not frozen during hold shows as an early rising edge as soon as `hold` drops. A reference model that compares the outputs every cycle therefore reports any of these faults within one period.

// File: rtl/scl_gen_pkg.sv
package scl_gen_pkg;
  localparam int unsigned CNT_W     = 16;
  localparam int unsigned MIN_COUNT = 4;
  localparam logic        SEL_HIGH  = 1'b0;
  localparam logic        SEL_LOW   = 1'b1;
endpackage

// File: rtl/scl_period_reg.sv
module scl_period_reg #(
  parameter int unsigned W      = 16,
  parameter int unsigned FLOOR  = 4,
  parameter logic        MY_SEL = 1'b0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         wr_en,
  input  logic         wr_sel,
  input  logic [W-1:0] wr_data,
  output logic [W-1:0] count_o
);
  localparam logic [W-1:0] FLOOR_V = W'(FLOOR);

  function automatic logic [W-1:0] floor_count(input logic [W-1:0] v);
    return (v < FLOOR_V) ? FLOOR_V : v;
  endfunction

  logic          hit_w;
  logic [W-1:0]  count_q;

  assign hit_w = wr_en && (wr_sel == MY_SEL);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     count_q <= FLOOR_V;
    else if (hit_w) count_q <= floor_count(wr_data);
  end

  assign count_o = count_q;

  // R4
  count_floor_chk: assert property (@(posedge clk) disable iff (!rst_n)
    count_q >= FLOOR_V);

  // R4
  count_untouched_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !hit_w |=> $stable(count_q));
endmodule

// File: rtl/scl_phase_seq.sv
module scl_phase_seq #(
  parameter int unsigned W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         enable,
  input  logic         hold,
  input  logic [W-1:0] high_len,
  input  logic [W-1:0] low_len,
  output logic         pull_low,
  output logic         tick_rise,
  output logic         tick_fall
);
  localparam logic [W-1:0] ONE = W'(1);

  logic         run_q, low_q, rise_q, fall_q;
  logic [W-1:0] cnt_q, len_q;

  logic start_w, stall_w, phase_end_w;
  assign start_w     = enable && !run_q;
  assign stall_w     = run_q && low_q && hold;
  assign phase_end_w = run_q && !stall_w && (cnt_q == len_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q <= 1'b0; low_q <= 1'b0; cnt_q <= '0; len_q <= '0;
      rise_q <= 1'b0; fall_q <= 1'b0;
    end else if (!enable) begin
      run_q <= 1'b0; low_q <= 1'b0; cnt_q <= '0; len_q <= '0;
      rise_q <= 1'b0; fall_q <= 1'b0;
    end else if (start_w) begin
      run_q <= 1'b1; low_q <= 1'b1; cnt_q <= ONE; len_q <= low_len;
      rise_q <= 1'b0; fall_q <= 1'b1;
    end else if (phase_end_w) begin
      low_q  <= !low_q;
      cnt_q  <= ONE;
      len_q  <= low_q ? high_len : low_len;
      rise_q <= low_q;
      fall_q <= !low_q;
    end else begin
      rise_q <= 1'b0;
      fall_q <= 1'b0;
      if (!stall_w) cnt_q <= cnt_q + ONE;
    end
  end

  assign pull_low  = run_q && low_q;
  assign tick_rise = rise_q;
  assign tick_fall = fall_q;

  // R9
  ticks_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(tick_rise && tick_fall));

  // R9
  fall_in_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tick_fall |-> pull_low);

  // R9
  rise_in_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tick_rise |-> (run_q && !pull_low));

  // R7
  hold_freeze_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (enable && stall_w) |=> (pull_low && $stable(cnt_q)));

  // R6
  len_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (enable && run_q && !phase_end_w) |=> $stable(len_q));

  // R8
  release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !enable |=> (!pull_low && cnt_q == '0));

  // R5
  start_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start_w |=> (pull_low && tick_fall));

  // R2
  cnt_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    run_q |-> (cnt_q >= ONE && cnt_q <= len_q));
endmodule

// File: rtl/scl_rate_gen.sv
module scl_rate_gen
  import scl_gen_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic             wr_sel,
  input  logic [CNT_W-1:0] wr_data,
  input  logic             enable,
  input  logic             hold,
  output logic             scl_pull_low,
  output logic             tick_rise,
  output logic             tick_fall
);
  logic [CNT_W-1:0] len_w [2];

  for (genvar g = 0; g < 2; g++) begin : g_period
    scl_period_reg #(
      .W     (CNT_W),
      .FLOOR (MIN_COUNT),
      .MY_SEL(g == 0 ? SEL_HIGH : SEL_LOW)
    ) reg_i (
      .clk    (clk),
      .rst_n  (rst_n),
      .wr_en  (wr_en),
      .wr_sel (wr_sel),
      .wr_data(wr_data),
      .count_o(len_w[g])
    );
  end

  scl_phase_seq #(.W(CNT_W)) seq_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .enable   (enable),
    .hold     (hold),
    .high_len (len_w[0]),
    .low_len  (len_w[1]),
    .pull_low (scl_pull_low),
    .tick_rise(tick_rise),
    .tick_fall(tick_fall)
  );
endmodule

// File: tb/scl_rate_gen_tb.sv
module scl_rate_gen_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic wr_en = 1'b0, wr_sel = 1'b0, enable = 1'b0, hold = 1'b0;
  logic [15:0] wr_data = '0;
  logic scl_pull_low, tick_rise, tick_fall;

  always #5 clk = ~clk;

  scl_rate_gen dut_i (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel),
    .wr_data(wr_data), .enable(enable), .hold(hold),
    .scl_pull_low(scl_pull_low), .tick_rise(tick_rise), .tick_fall(tick_fall)
  );

  int compared = 0, mismatched = 0;
  string cur_req = "R1";
  bit finished = 1'b0;

  // Behavioural reference: time remaining in the current phase.
  int  m_hi = 4, m_lo = 4;
  bit  m_active = 0, m_in_low = 0, m_rise = 0, m_fall = 0;
  int  m_left = 0;

  function automatic int floor4(input int v);
    return (v < 4) ? 4 : v;
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_hi = 4; m_lo = 4; m_active = 0; m_in_low = 0;
      m_rise = 0; m_fall = 0; m_left = 0;
    end else begin
      m_rise = 0; m_fall = 0;
      if (!enable) begin
        m_active = 0; m_in_low = 0; m_left = 0;
      end else if (!m_active) begin
        m_active = 1; m_in_low = 1; m_left = m_lo; m_fall = 1;
      end else if (m_in_low && hold) begin
        // stretched: nothing moves
      end else if (m_left == 1) begin
        m_in_low = !m_in_low;
        m_left   = m_in_low ? m_lo : m_hi;
        m_rise   = !m_in_low;
        m_fall   = m_in_low;
      end else begin
        m_left = m_left - 1;
      end
      if (wr_en) begin
        if (wr_sel) m_lo = floor4(int'(wr_data));
        else        m_hi = floor4(int'(wr_data));
      end
    end
  end

  task automatic check(input string req, input int act, input int exp, input string what);
    compared++;
    if (act != exp) begin
      mismatched++;
      $display("FAIL %s %s: actual=%0d expected=%0d at %0t", req, what, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n && !finished) begin
      check(cur_req, {29'd0, scl_pull_low, tick_rise, tick_fall},
            {29'd0, m_active && m_in_low, m_rise, m_fall}, "pull_low/rise/fall");
    end
  end

  task automatic wr(input logic sel, input int val);
    @(negedge clk);
    wr_en = 1'b1; wr_sel = sel; wr_data = 16'(val);
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic wait_cycles(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  endtask

  initial begin
    #2000000;
    compared++; mismatched++;
    $display("FAIL watchdog: actual=timeout expected=done");
    finish_run();
  end

  initial begin
    wait_cycles(4);
    // R1: reset state at the ports
    check("R1", scl_pull_low, 0, "pull_low in reset");
    check("R1", tick_rise | tick_fall, 0, "ticks in reset");
    rst_n = 1'b1;
    wait_cycles(2);
    check("R1", scl_pull_low, 0, "idle pull_low");
    // R1, R2, R3, R5: default 4/4 counts from enable
    cur_req = "R5";
    enable = 1'b1;
    @(negedge clk);
    check("R5", {31'd0, tick_fall}, 1, "fall tick on start");
    cur_req = "R1";
    wait_cycles(30);
    // R2 R3: asymmetric counts
    cur_req = "R3";
    wr(1'b0, 6);
    wr(1'b1, 11);
    wait_cycles(70);
    // R6: write in the middle of a low phase
    cur_req = "R6";
    wait (tick_fall == 1'b1);
    wait_cycles(3);
    wr(1'b1, 5);
    wr(1'b0, 9);
    wait_cycles(60);
    // R4: values below the floor
    cur_req = "R4";
    wr(1'b1, 2);
    wr(1'b0, 0);
    wait_cycles(40);
    wr(1'b1, 3);
    wr(1'b0, 4);
    wait_cycles(40);
    // R2: long low phase
    cur_req = "R2";
    wr(1'b1, 300);
    wr(1'b0, 7);
    wait_cycles(700);
    wr(1'b1, 8);
    wait_cycles(350);
    // R7: hold inside a low phase
    cur_req = "R7";
    wait (tick_fall == 1'b1);
    wait_cycles(2);
    hold = 1'b1;
    wait_cycles(9);
    check("R7", scl_pull_low, 1, "held low");
    hold = 1'b0;
    wait_cycles(30);
    wait (tick_fall == 1'b1);
    wait_cycles(7);
    hold = 1'b1;
    wait_cycles(4);
    hold = 1'b0;
    wait_cycles(30);
    // R10: hold during the high phase
    cur_req = "R10";
    wait (tick_rise == 1'b1);
    @(negedge clk);
    hold = 1'b1;
    wait_cycles(5);
    hold = 1'b0;
    wait_cycles(30);
    // R8: disable and restart
    cur_req = "R8";
    wait (tick_fall == 1'b1);
    wait_cycles(2);
    enable = 1'b0;
    @(negedge clk);
    check("R8", scl_pull_low, 0, "released after disable");
    wait_cycles(3);
    enable = 1'b1;
    @(negedge clk);
    check("R8", {31'd0, tick_fall}, 1, "restart with fall tick");
    wait_cycles(40);
    // R9: short disable during high phase
    cur_req = "R9";
    wait (tick_rise == 1'b1);
    enable = 1'b0;
    @(negedge clk);
    enable = 1'b1;
    wait_cycles(60);
    finish_run();
  end
endmodule